// File: doc/BRIEF.md
# Interrupt Pending and Mask Unit

This block gathers interrupt requests from two kinds of source into one 32-bit pending vector. The upper positions mirror request lines from on-chip peripherals. The lower positions come from external active-low request pins. Each pin passes through a two-flop synchronizer. A per-pin sensitivity bit then decides how the pin's pending bit behaves. In level mode the bit tracks the pin. In edge mode the bit latches a falling edge and holds it until software clears it by writing a one to that bit.

A mask register selects which pending bits may raise the single combined interrupt output. Alongside that output the block reports the lowest-numbered pending bit that is also enabled, with a valid flag. Software reaches the pending, mask and sensitivity registers through a small synchronous port. Writes take effect at the clock edge. Read data is registered and appears one cycle after the address is presented.

Top module: `irq_pend_unit`

## Requirements
- R1: Pending bit N_PIN+i (with defaults, bits 8..31) equals internal request line i, two cycles of latency not applying: it is set while the line is high and clear while it is low.
- R2: A write to the pending register (address 0) leaves every internal-source bit unchanged, whatever the written value.
- R3: The sensitivity register (address 2) holds one bit per pin, bit k for pin k: 1 selects edge mode and 0 selects level mode. It resets to all zeros, so every pin starts in level mode.
- R4: In level mode, pending bit k reads 1 while pin k is low and 0 while it is high, after a two-cycle synchronizer; writes to that bit have no effect.
- R5: In edge mode, a high-to-low transition on pin k sets pending bit k, and the bit stays set after the pin returns high.
- R6: In edge mode, writing 1 to pending bit k at address 0 clears it, and writing 0 leaves it unchanged.
- R7: When a new falling edge on pin k and a write of 1 to bit k land in the same cycle, the bit stays set.
- R8: Switching pin k from edge mode to level mode discards any latched edge; the bit then follows the pin.
- R9: The mask register (address 1) resets to all zeros. The output irq_out is high exactly when some bit is set in both the pending and the mask registers.
- R10: act_idx gives the lowest-numbered bit set in both the pending and the mask registers, and act_valid is high whenever such a bit exists.
- R11: reg_rdata shows, one cycle after the address is presented, the pending register at address 0, the mask at address 1, the sensitivity bits zero-extended at address 2, and zero at address 3.
- R12: A write to address 1 replaces the mask with the written value, and the new mask can be read back at the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_req | input | WIDTH-N_PIN | Internal peripheral request lines, active high |
| irq_pin_n | input | N_PIN | External request pins, active low, asynchronous |
| reg_addr | input | 2 | Register select: 0 pending, 1 mask, 2 sensitivity |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Registered read data |
| irq_out | output | 1 | Combined interrupt request |
| act_idx | output | $clog2(WIDTH) | Lowest enabled pending bit index |
| act_valid | output | 1 | act_idx is meaningful |

## Verification
A fault in the edge latch shows in one of two ways: a pending bit that vanishes when the pin rises, or a bit that survives a write-one-to-clear. Either shows in the registered read one cycle after the address is presented, and in irq_out as soon as the bit is masked in. A wrong set-versus-clear priority shows only when the clear write and the detected edge share a single cycle, so the bench times that write to the exact cycle. A wrong mask or sensitivity state shows up the same cycle on irq_out and act_idx.

// File: rtl/irq_pend_pkg.sv
// Shared register map for the interrupt pending and mask unit.
// Assumes a two-bit register address space.
package irq_pend_pkg;
    typedef enum logic [1:0] {
        REG_PEND = 2'd0,
        REG_MASK = 2'd1,
        REG_SENS = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/irq_sync2.sv
// Two-flop synchronizer for asynchronous active-low request pins.
// Assumes that the idle pin level is high, so the flops reset to 1.
module irq_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            stab_q <= '1;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
        end
    end

    assign dout = stab_q;
endmodule

// File: rtl/irq_pin_slot.sv
// Pending-bit logic for one external pin. In level mode the bit is the
// inverted synchronized pin. In edge mode it latches a high-to-low
// transition until a clear. A set wins over a clear in the same cycle.
// Leaving edge mode drops the latch. Assumes that pin_cur is already
// synchronized.
module irq_pin_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_cur,
    input  logic edge_mode,
    input  logic clr_hit,
    output logic pend
);
    logic prev_q;
    logic latch_q;
    logic fall;

    assign fall = prev_q & ~pin_cur;

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_cur;
    end

    // Latch falling edges; set beats clear; level mode empties the latch.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= 1'b0;
        else if (!edge_mode) latch_q <= 1'b0;
        else if (fall)       latch_q <= 1'b1;
        else if (clr_hit)    latch_q <= 1'b0;
    end

    assign pend = edge_mode ? latch_q : ~pin_cur;
endmodule

// File: rtl/irq_low_find.sv
// Finds the lowest-numbered set bit of a vector, combinationally.
// Assumes that W is a power of two or that IW covers W-1.
module irq_low_find #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    // Scan from the top so that the lowest set bit is the last one assigned.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_pend_unit.sv
// Interrupt pending and mask unit. Bits [N_PIN-1:0] belong to the external
// pins, and bits above them mirror the internal request lines. The register
// port decodes addresses 0 pending, 1 mask and 2 sensitivity. Writes act at
// the clock edge. Read data is registered.
module irq_pend_unit #(
    parameter int WIDTH = 32,
    parameter int N_PIN = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WIDTH-N_PIN-1:0]     int_req,
    input  logic [N_PIN-1:0]           irq_pin_n,
    input  logic [1:0]                 reg_addr,
    input  logic                       reg_wr,
    input  logic [WIDTH-1:0]           reg_wdata,
    output logic [WIDTH-1:0]           reg_rdata,
    output logic                       irq_out,
    output logic [$clog2(WIDTH)-1:0]   act_idx,
    output logic                       act_valid
);
    import irq_pend_pkg::*;

    localparam int N_INT = WIDTH - N_PIN;
    localparam int IW    = $clog2(WIDTH);

    logic [WIDTH-1:0] mask_q;
    logic [N_PIN-1:0] sens_q;
    logic [N_PIN-1:0] pin_cur;
    logic [WIDTH-1:0] pend_vec;
    logic [WIDTH-1:0] enabled;
    reg_sel_t         sel;

    assign sel = reg_sel_t'(reg_addr);

    irq_sync2 #(.W(N_PIN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_pin_n),
        .dout (pin_cur)
    );

    for (genvar k = 0; k < N_PIN; k++) begin : g_pin
        irq_pin_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_cur  (pin_cur[k]),
            .edge_mode(sens_q[k]),
            .clr_hit  (reg_wr && sel == REG_PEND && reg_wdata[k]),
            .pend     (pend_vec[k])
        );
    end

    assign pend_vec[WIDTH-1:N_PIN] = int_req[N_INT-1:0];

    // Mask and sensitivity registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            sens_q <= '0;
        end else if (reg_wr) begin
            if (sel == REG_MASK) mask_q <= reg_wdata;
            if (sel == REG_SENS) sens_q <= reg_wdata[N_PIN-1:0];
        end
    end

    // Registered read multiplexer.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else begin
            unique case (sel)
                REG_PEND: reg_rdata <= pend_vec;
                REG_MASK: reg_rdata <= mask_q;
                REG_SENS: reg_rdata <= WIDTH'(sens_q);
                default:  reg_rdata <= '0;
            endcase
        end
    end

    assign enabled = pend_vec & mask_q;
    assign irq_out = |enabled;

    irq_low_find #(.W(WIDTH), .IW(IW)) u_find (
        .vec  (enabled),
        .idx  (act_idx),
        .found(act_valid)
    );
endmodule

// File: rtl/irq_pend_unit_chk.sv
// Property checker for irq_pend_unit, attached with bind below.
module irq_pend_unit_chk #(
    parameter int WIDTH = 32,
    parameter int N_PIN = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               reg_addr,
    input logic                     reg_wr,
    input logic [WIDTH-1:0]         reg_wdata,
    input logic [WIDTH-1:0]         pend_vec,
    input logic [WIDTH-1:0]         mask_q,
    input logic [N_PIN-1:0]         sens_q,
    input logic                     irq_out,
    input logic [$clog2(WIDTH)-1:0] act_idx,
    input logic                     act_valid
);
    // R9
    irq_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> act_valid);

    // R10
    idx_hits_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (pend_vec[act_idx] && mask_q[act_idx]));

    // R10
    idx_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> ((pend_vec & mask_q & ~({WIDTH{1'b1}} << act_idx)) == '0));

    // R12
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> (mask_q == $past(reg_wdata)));

    for (genvar k = 0; k < N_PIN; k++) begin : g_hold
        // R5
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sens_q[k] && pend_vec[k]
             && !(reg_wr && reg_addr == 2'd0 && reg_wdata[k])
             && !(reg_wr && reg_addr == 2'd2)) |=> pend_vec[k]);
    end
endmodule

bind irq_pend_unit irq_pend_unit_chk #(.WIDTH(WIDTH), .N_PIN(N_PIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .pend_vec (pend_vec),
    .mask_q   (mask_q),
    .sens_q   (sens_q),
    .irq_out  (irq_out),
    .act_idx  (act_idx),
    .act_valid(act_valid)
);

// File: tb/test_irq_pend_unit.sv
// Directed bench for irq_pend_unit: one task per scenario.
module test_irq_pend_unit;
    localparam int WIDTH = 32;
    localparam int N_PIN = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WIDTH-N_PIN-1:0] int_req = '0;
    logic [N_PIN-1:0]  irq_pin_n = '1;
    logic [1:0]        reg_addr = 2'd0;
    logic              reg_wr = 1'b0;
    logic [WIDTH-1:0]  reg_wdata = '0;
    logic [WIDTH-1:0]  reg_rdata;
    logic              irq_out;
    logic [4:0]        act_idx;
    logic              act_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_pend_unit #(.WIDTH(WIDTH), .N_PIN(N_PIN)) i_irq_pend_unit (
        .clk(clk), .rst_n(rst_n), .int_req(int_req), .irq_pin_n(irq_pin_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .act_idx(act_idx),
        .act_valid(act_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd1, d); check("R9 mask reset", d, 32'h0);
        rd(2'd2, d); check("R3 sens reset", d, 32'h0);
        rd(2'd0, d); check("R11 pending reset", d, 32'h0);
        rd(2'd3, d); check("R11 addr3 zero", d, 32'h0);
        check("R9 irq idle", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_internal();
        logic [31:0] d;
        int_req = 24'h000501;
        settle();
        rd(2'd0, d); check("R1 mirror", d, 32'h00050100);
        wr(2'd0, 32'hFFFFFFFF);
        rd(2'd0, d); check("R2 write ignored set", d, 32'h00050100);
        int_req = '0;
        wr(2'd0, 32'hFFFFFF00);
        rd(2'd0, d); check("R2 write ignored clear", d, 32'h0);
        check("R1 irq still masked", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        irq_pin_n[3] = 1'b0;
        settle();
        rd(2'd0, d); check("R4 level low", d, 32'h00000008);
        wr(2'd0, 32'h8);
        rd(2'd0, d); check("R4 level write ignored", d, 32'h00000008);
        irq_pin_n[3] = 1'b1;
        settle();
        rd(2'd0, d); check("R4 level follows high", d, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(2'd2, 32'h00000024);
        rd(2'd2, d); check("R3 sens readback", d, 32'h24);
        irq_pin_n[2] = 1'b0;
        settle();
        irq_pin_n[2] = 1'b1;
        settle();
        rd(2'd0, d); check("R5 edge latched", d, 32'h00000004);
        wr(2'd0, 32'h0);
        rd(2'd0, d); check("R6 write0 keeps", d, 32'h00000004);
        wr(2'd0, 32'h4);
        rd(2'd0, d); check("R6 write1 clears", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        irq_pin_n[5] = 1'b0;
        settle();
        irq_pin_n[5] = 1'b1;
        settle();
        // Second fall: drive at N0; edge detect is live in the cycle ending at the third posedge.
        @(negedge clk); irq_pin_n[5] = 1'b0;
        @(negedge clk);
        @(negedge clk); reg_addr = 2'd0; reg_wdata = 32'h20; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd0, d); check("R7 set wins", d, 32'h00000020);
        irq_pin_n[5] = 1'b1;
        settle();
        wr(2'd0, 32'h20);
        rd(2'd0, d); check("R7 cleared after", d, 32'h0);
    endtask

    task automatic t_mode_switch();
        logic [31:0] d;
        irq_pin_n[2] = 1'b0;
        settle();
        irq_pin_n[2] = 1'b1;
        settle();
        rd(2'd0, d); check("R8 latched before", d, 32'h4);
        wr(2'd2, 32'h0);
        rd(2'd0, d); check("R8 level discards", d, 32'h0);
        wr(2'd2, 32'h4);
        rd(2'd0, d); check("R8 stays empty back in edge", d, 32'h0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_mask_prio();
        logic [31:0] d;
        wr(2'd1, 32'hA5A5F0F0);
        rd(2'd1, d); check("R12 mask readback", d, 32'hA5A5F0F0);
        wr(2'd1, 32'h0);
        int_req = 24'h000410; // bits 12 and 18
        irq_pin_n[6] = 1'b0;  // bit 6, level
        settle();
        check("R9 all masked", {31'b0, irq_out}, 32'h0);
        check("R10 no valid", {31'b0, act_valid}, 32'h0);
        wr(2'd1, 32'h00041000);
        @(negedge clk);
        check("R9 irq on", {31'b0, irq_out}, 32'h1);
        check("R10 idx 12", {27'b0, act_idx}, 32'd12);
        wr(2'd1, 32'hFFFFFFFF);
        @(negedge clk);
        check("R10 idx 6", {27'b0, act_idx}, 32'd6);
        check("R10 valid", {31'b0, act_valid}, 32'h1);
        irq_pin_n[6] = 1'b1;
        int_req = 24'h800000; // bit 31
        settle();
        check("R10 idx 31", {27'b0, act_idx}, 32'd31);
        int_req = '0;
        settle();
        check("R9 irq off", {31'b0, irq_out}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_internal();
        t_level();
        t_edge();
        t_set_wins();
        t_mode_switch();
        t_mask_prio();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule